// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block holds the sample buffering for a serial audio port. One FIFO carries outgoing samples: the bus writes 16-bit samples into it and the serial shifter pops them. The other carries incoming samples the opposite way: the shifter pushes them and the bus reads them. Each FIFO reports an occupancy count and four level flags. A 6-bit threshold per direction sets the almost-empty level, the almost-full level and the level at which that direction asks for a DMA transfer.

Two error conditions per direction are held sticky: starvation, which is a pop from an empty FIFO, and overflow, which is a push into a full one. A 12-bit status vector collects the sticky errors and the live level flags. A per-source mask and a global enable gate that vector into one sticky interrupt pending bit. A single clear strobe drops the pending bit and every sticky error.

Top module: `sfifo_top`

## Requirements
- R1: After reset, both counts are 0, both empty flags are set, no sticky error is set, `irq_pend` is 0 and both DMA requests are 0.
- R2: Samples leave each FIFO in the order they entered. Bit 16 of `ser_tx_word` and `bus_rx_word` is 1 with the head sample in bits 15:0 when that FIFO holds data, and bit 16 is 0 when it is empty.
- R3: The count equals the occupancy, from 0 to 32 entries. An accepted push and an accepted pop in the same cycle leave the count unchanged.
- R4: The flag vectors are laid out as bit0 empty (count = 0), bit1 almost-empty (count <= threshold), bit2 full (count = 32) and bit3 almost-full (count >= threshold).
- R5: A push into a full FIFO is dropped, and the count stays 32. It sets the sticky overflow bit: status bit 6 for TX and bit 0 for RX.
- R6: A pop from an empty FIFO leaves the count at 0 and sets the sticky starve bit. A serial TX pop sets status bit 7 and a bus RX read sets bit 1.
- R7: `tx_dma_req` is high while TX DMA and the TX FIFO are enabled and TX is almost-empty. `rx_dma_req` is high while RX DMA and the RX FIFO are enabled and RX is almost-full.
- R8: `irq_status` bits are: 0 RX overflow, 1 RX starve, 2 RX almost-full, 3 RX full, 4 RX almost-empty, 5 RX empty, 6 TX overflow, 7 TX starve, 8 TX almost-full, 9 TX full, 10 TX almost-empty, 11 TX empty. The level bits track the flags live.
- R9: `irq_pend` sets one cycle after a status bit whose `irq_mask` bit is 1 is seen while `irq_gen_en` is 1. It then stays set until a clear. While `irq_gen_en` is 0 it does not set.
- R10: A one-cycle `irq_clr` clears `irq_pend` and all sticky errors at the next edge. An enabled level source that is still active sets `irq_pend` again one cycle later.
- R11: While a FIFO's enable is 0, its count is held at 0, and pushes and pops to it are ignored without raising any error. `port_en` is the OR of the two FIFO enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fifo_en | input | 1 | TX FIFO enable; low flushes it |
| rx_fifo_en | input | 1 | RX FIFO enable; low flushes it |
| tx_dma_en | input | 1 | Allows the TX DMA request |
| rx_dma_en | input | 1 | Allows the RX DMA request |
| tx_thr | input | 6 | TX threshold |
| rx_thr | input | 6 | RX threshold |
| irq_gen_en | input | 1 | Global interrupt enable |
| irq_mask | input | 12 | Per-source enables, same layout as `irq_status` |
| irq_clr | input | 1 | Clear strobe for pending and sticky errors |
| bus_tx_wr | input | 1 | Bus write strobe into TX |
| bus_tx_data | input | 16 | Bus write sample |
| bus_rx_rd | input | 1 | Bus read strobe from RX |
| bus_rx_word | output | 17 | RX head: valid bit 16, sample 15:0 |
| ser_tx_pop | input | 1 | Serial pop strobe from TX |
| ser_tx_word | output | 17 | TX head: valid bit 16, sample 15:0 |
| ser_rx_push | input | 1 | Serial push strobe into RX |
| ser_rx_data | input | 16 | Serial push sample |
| tx_count | output | 6 | TX occupancy |
| rx_count | output | 6 | RX occupancy |
| tx_flags | output | 4 | TX level flags |
| rx_flags | output | 4 | RX level flags |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| irq_status | output | 12 | Sticky errors and live level flags |
| irq_pend | output | 1 | Sticky interrupt pending |
| port_en | output | 1 | Port enable |

## Verification
The assertions assume that every strobe, enable and clear is synchronous to `clk` and free of X after reset. They also assume that a clear lasts one cycle, so the window after it is read as a single event. They place no limit on the thresholds, so any 6-bit value, including values above the depth, must keep them true. The bench changes inputs one time unit after the rising edge and samples in mid-cycle. It never lets an empty FIFO see a push and a pop in the same cycle, so the scoreboard queue order matches the hardware order.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned DEF_DEPTH  = 32;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_THR_W  = 6;
  localparam int unsigned NSRC       = 12;

  // status / mask bit positions
  localparam int unsigned S_RX_OVF = 0;
  localparam int unsigned S_RX_STV = 1;
  localparam int unsigned S_RX_AF  = 2;
  localparam int unsigned S_RX_FU  = 3;
  localparam int unsigned S_RX_AE  = 4;
  localparam int unsigned S_RX_EM  = 5;
  localparam int unsigned S_TX_OVF = 6;
  localparam int unsigned S_TX_STV = 7;
  localparam int unsigned S_TX_AF  = 8;
  localparam int unsigned S_TX_FU  = 9;
  localparam int unsigned S_TX_AE  = 10;
  localparam int unsigned S_TX_EM  = 11;

  localparam logic [NSRC-1:0] STICKY_SRC = 12'b0000_1100_0011;

  typedef struct packed {
    logic almost_full;
    logic full;
    logic almost_empty;
    logic empty;
  } lvl_t;

  function automatic logic at_or_below(int unsigned c, int unsigned t);
    return c <= t;
  endfunction

  function automatic logic at_or_above(int unsigned c, int unsigned t);
    return c >= t;
  endfunction

  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sfifo_buf.sv
module sfifo_buf
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned THR_W  = DEF_THR_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [THR_W-1:0]  thr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_valid,
  output logic [CNT_W-1:0]  count,
  output lvl_t              lvl,
  output logic              ovf_ev,
  output logic              stv_ev
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign lvl.empty        = (cnt_q == '0);
  assign lvl.full         = (cnt_q == CNT_W'(DEPTH));
  assign lvl.almost_empty = at_or_below(32'(cnt_q), 32'(thr));
  assign lvl.almost_full  = at_or_above(32'(cnt_q), 32'(thr));

  assign push_ok = en & push & ~lvl.full;
  assign pop_ok  = en & pop  & ~lvl.empty;
  assign ovf_ev  = en & push & lvl.full;
  assign stv_ev  = en & pop  & lvl.empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (!en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(ptr_next(32'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(ptr_next(32'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign head_data  = mem[rd_ptr];
  assign head_valid = ~lvl.empty;
  assign count      = cnt_q;

  // R3: occupancy never exceeds depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R3: balanced push and pop keep the count
  p_balanced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && pop && !lvl.full && !lvl.empty) |=> $stable(cnt_q));
  // R5: a push into a full FIFO is dropped
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && !pop && lvl.full) |=> (cnt_q == CNT_W'(DEPTH)));
  // R6: a pop from an empty FIFO leaves it empty
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pop && !push && lvl.empty) |=> (cnt_q == '0));
  // R11: a disabled FIFO is flushed
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/sfifo_irq_ctl.sv
module sfifo_irq_ctl #(
  parameter int unsigned      NSRC   = 12,
  parameter logic [NSRC-1:0]  STICKY = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            gen_en,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] src,
  output logic            pend
);
  logic pend_q;
  logic hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (STICKY[i]) begin : g_sticky
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= 1'b0;
        else if (clr) st_q <= ev[i];
        else          st_q <= st_q | ev[i];
      end
      assign src[i] = st_q;
    end else begin : g_live
      assign src[i] = ev[i];
    end
  end

  assign hit = gen_en & |(src & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (clr) pend_q <= 1'b0;
    else          pend_q <= pend_q | hit;
  end

  assign pend = pend_q;

  // R9: pending holds until cleared
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);
  // R9: no new pending while the global enable is low
  p_pend_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !pend_q) |=> !pend_q);
  // R10: a clear drops pending at the next edge
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend_q);
  // R10: a clear without a new event empties every sticky source
  p_sticky_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ((ev & STICKY) == '0)) |=> ((src & STICKY) == '0));
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned THR_W  = DEF_THR_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_fifo_en,
  input  logic              rx_fifo_en,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic [THR_W-1:0]  tx_thr,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic              irq_gen_en,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic              irq_clr,
  input  logic              bus_tx_wr,
  input  logic [DATA_W-1:0] bus_tx_data,
  input  logic              bus_rx_rd,
  output logic [DATA_W:0]   bus_rx_word,
  input  logic              ser_tx_pop,
  output logic [DATA_W:0]   ser_tx_word,
  input  logic              ser_rx_push,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic [3:0]        tx_flags,
  output logic [3:0]        rx_flags,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic [NSRC-1:0]   irq_status,
  output logic              irq_pend,
  output logic              port_en
);
  lvl_t              tx_lvl, rx_lvl;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic              tx_hv, rx_hv;
  logic              tx_ovf_ev, tx_stv_ev, rx_ovf_ev, rx_stv_ev;
  logic [NSRC-1:0]   ev_vec;

  sfifo_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_fifo_en), .thr(tx_thr),
    .push(bus_tx_wr), .push_data(bus_tx_data), .pop(ser_tx_pop),
    .head_data(tx_head), .head_valid(tx_hv), .count(tx_count),
    .lvl(tx_lvl), .ovf_ev(tx_ovf_ev), .stv_ev(tx_stv_ev)
  );

  sfifo_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_fifo_en), .thr(rx_thr),
    .push(ser_rx_push), .push_data(ser_rx_data), .pop(bus_rx_rd),
    .head_data(rx_head), .head_valid(rx_hv), .count(rx_count),
    .lvl(rx_lvl), .ovf_ev(rx_ovf_ev), .stv_ev(rx_stv_ev)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[S_RX_OVF] = rx_ovf_ev;
    ev_vec[S_RX_STV] = rx_stv_ev;
    ev_vec[S_RX_AF]  = rx_lvl.almost_full;
    ev_vec[S_RX_FU]  = rx_lvl.full;
    ev_vec[S_RX_AE]  = rx_lvl.almost_empty;
    ev_vec[S_RX_EM]  = rx_lvl.empty;
    ev_vec[S_TX_OVF] = tx_ovf_ev;
    ev_vec[S_TX_STV] = tx_stv_ev;
    ev_vec[S_TX_AF]  = tx_lvl.almost_full;
    ev_vec[S_TX_FU]  = tx_lvl.full;
    ev_vec[S_TX_AE]  = tx_lvl.almost_empty;
    ev_vec[S_TX_EM]  = tx_lvl.empty;
  end

  sfifo_irq_ctl #(.NSRC(NSRC), .STICKY(STICKY_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(irq_clr), .gen_en(irq_gen_en),
    .ev(ev_vec), .mask(irq_mask), .src(irq_status), .pend(irq_pend)
  );

  assign ser_tx_word = {tx_hv, tx_head};
  assign bus_rx_word = {rx_hv, rx_head};
  assign tx_flags    = tx_lvl;
  assign rx_flags    = rx_lvl;
  assign tx_dma_req  = tx_dma_en & tx_fifo_en & tx_lvl.almost_empty;
  assign rx_dma_req  = rx_dma_en & rx_fifo_en & rx_lvl.almost_full;
  assign port_en     = tx_fifo_en | rx_fifo_en;

  // R7: DMA requests follow the counts from the FIFO instances
  p_tx_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (tx_count <= CNT_W'(tx_thr)));
  p_rx_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (rx_count >= CNT_W'(rx_thr)));
  // R2: a valid head exactly when data is held
  p_tx_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_word[DATA_W] == (tx_count != '0));
endmodule

// File: tb/sfifo_top_tb_top.sv
module sfifo_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_fifo_en = 0, rx_fifo_en = 0, tx_dma_en = 0, rx_dma_en = 0;
  logic [5:0]  tx_thr = 6'd4, rx_thr = 6'd8;
  logic        irq_gen_en = 0, irq_clr = 0;
  logic [11:0] irq_mask = '0;
  logic        bus_tx_wr = 0, bus_rx_rd = 0, ser_tx_pop = 0, ser_rx_push = 0;
  logic [15:0] bus_tx_data = '0, ser_rx_data = '0;
  logic [16:0] bus_rx_word, ser_tx_word;
  logic [5:0]  tx_count, rx_count;
  logic [3:0]  tx_flags, rx_flags;
  logic        tx_dma_req, rx_dma_req, irq_pend, port_en;
  logic [11:0] irq_status;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] tx_q[$], rx_q[$];
  logic [11:0] exp_err = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfifo_top dut_i (
    .clk(clk), .rst_n(rst_n), .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .irq_gen_en(irq_gen_en), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .bus_tx_wr(bus_tx_wr), .bus_tx_data(bus_tx_data), .bus_rx_rd(bus_rx_rd),
    .bus_rx_word(bus_rx_word), .ser_tx_pop(ser_tx_pop), .ser_tx_word(ser_tx_word),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .tx_count(tx_count),
    .rx_count(rx_count), .tx_flags(tx_flags), .rx_flags(rx_flags),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq_status(irq_status),
    .irq_pend(irq_pend), .port_en(port_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input int c, input int t);
    return {c >= t, c == 32, c <= t, c == 0};
  endfunction

  function automatic logic [11:0] exp_status(input int tc, input int rc);
    logic [3:0] tf, rf;
    tf = exp_flags(tc, int'(tx_thr));
    rf = exp_flags(rc, int'(rx_thr));
    return exp_err | {tf[0], tf[1], tf[2], tf[3], 2'b00, rf[0], rf[1], rf[2], rf[3], 2'b00};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(input logic [15:0] d);
    bus_tx_wr = 1; bus_tx_data = d;
    if (tx_fifo_en && tx_q.size() < 32) tx_q.push_back(d);
    step(); bus_tx_wr = 0;
  endtask

  task automatic ser_push(input logic [15:0] d);
    ser_rx_push = 1; ser_rx_data = d;
    if (rx_fifo_en && rx_q.size() < 32) rx_q.push_back(d);
    step(); ser_rx_push = 0;
  endtask

  task automatic ser_pop();
    ser_tx_pop = 1; step(); ser_tx_pop = 0;
  endtask

  task automatic bus_rd();
    bus_rx_rd = 1; step(); bus_rx_rd = 0;
  endtask

  // scoreboard monitor: compares the head word whenever a pop is presented
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ser_tx_pop && tx_fifo_en) begin
        if (tx_q.size() > 0) check("R2 tx order", 32'(ser_tx_word), 32'({1'b1, tx_q.pop_front()}));
        else                 check("R2 tx empty valid", 32'(ser_tx_word[16]), 0);
      end
      if (bus_rx_rd && rx_fifo_en) begin
        if (rx_q.size() > 0) check("R2 rx order", 32'(bus_rx_word), 32'({1'b1, rx_q.pop_front()}));
        else                 check("R2 rx empty valid", 32'(bus_rx_word[16]), 0);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tx_dma_en = 1; rx_dma_en = 1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    step();
    // R1 reset state
    check("R1 tx_count", 32'(tx_count), 0);
    check("R1 rx_count", 32'(rx_count), 0);
    check("R1 tx empty", 32'(tx_flags[0]), 1);
    check("R1 irq_pend", 32'(irq_pend), 0);
    check("R1 dma", 32'({tx_dma_req, rx_dma_req}), 0);
    check("R8 status at reset", 32'(irq_status), 32'(exp_status(0, 0)));
    check("R11 port_en off", 32'(port_en), 0);

    tx_fifo_en = 1; rx_fifo_en = 1; step();
    check("R11 port_en on", 32'(port_en), 1);

    for (int i = 0; i < 5; i++) bus_wr(16'h1000 + 16'(i));
    check("R3 tx count 5", 32'(tx_count), 5);
    check("R4 tx flags at 5", 32'(tx_flags), 32'(exp_flags(5, 4)));
    check("R7 tx dma above thr", 32'(tx_dma_req), 0);
    ser_pop();
    check("R7 tx dma at thr", 32'(tx_dma_req), 1);
    check("R4 tx flags at 4", 32'(tx_flags), 32'(exp_flags(4, 4)));

    // simultaneous push and pop
    bus_tx_wr = 1; bus_tx_data = 16'h1ABC; tx_q.push_back(16'h1ABC); ser_tx_pop = 1;
    step(); bus_tx_wr = 0; ser_tx_pop = 0;
    check("R3 push+pop count", 32'(tx_count), 4);

    for (int i = 0; i < 4; i++) ser_pop();
    check("R3 tx drained", 32'(tx_count), 0);
    check("R2 tx empty head", 32'(ser_tx_word[16]), 0);
    ser_pop();
    exp_err[7] = 1;
    check("R6 tx starve bit7", 32'(irq_status[7]), 1);
    check("R6 tx count after starve", 32'(tx_count), 0);

    for (int i = 0; i < 32; i++) bus_wr(16'h4000 + 16'(i * 3));
    check("R4 tx full flags", 32'(tx_flags), 32'(exp_flags(32, 4)));
    bus_wr(16'hDEAD);
    exp_err[6] = 1;
    check("R5 tx count stays 32", 32'(tx_count), 32);
    check("R5 tx overflow bit6", 32'(irq_status[6]), 1);
    for (int i = 0; i < 32; i++) ser_pop();
    check("R5 tx drained after overflow", 32'(tx_count), 0);

    for (int i = 0; i < 8; i++) ser_push(16'h2000 + 16'(i));
    check("R3 rx count 8", 32'(rx_count), 8);
    check("R4 rx flags at 8", 32'(rx_flags), 32'(exp_flags(8, 8)));
    check("R7 rx dma", 32'(rx_dma_req), 1);
    bus_rd();
    check("R7 rx dma below thr", 32'(rx_dma_req), 0);
    for (int i = 0; i < 7; i++) bus_rd();
    check("R2 rx empty head", 32'(bus_rx_word[16]), 0);
    bus_rd();
    exp_err[1] = 1;
    check("R6 rx starve bit1", 32'(irq_status[1]), 1);

    for (int i = 0; i < 33; i++) ser_push(16'h7000 + 16'(i * 5));
    exp_err[0] = 1;
    check("R5 rx count stays 32", 32'(rx_count), 32);
    check("R8 full status", 32'(irq_status), 32'(exp_status(0, 32)));
    for (int i = 0; i < 32; i++) bus_rd();

    // interrupt gating
    irq_mask = 12'hFFF; step(); step();
    check("R9 gen_en low", 32'(irq_pend), 0);
    irq_mask = 12'h040; irq_gen_en = 1; step();
    check("R9 pend sets", 32'(irq_pend), 1);
    step();
    check("R9 pend holds", 32'(irq_pend), 1);
    irq_clr = 1; step(); irq_clr = 0;
    exp_err = '0;
    check("R10 pend cleared", 32'(irq_pend), 0);
    check("R10 errors cleared", 32'(irq_status & 12'h0C3), 0);
    step();
    check("R10 stays clear", 32'(irq_pend), 0);

    irq_mask = 12'h800; step();
    check("R9 level source", 32'(irq_pend), 1);
    irq_clr = 1; step(); irq_clr = 0;
    check("R10 clear level", 32'(irq_pend), 0);
    step();
    check("R10 level re-sets", 32'(irq_pend), 1);
    irq_mask = '0; irq_clr = 1; step(); irq_clr = 0;

    // flush on disable
    for (int i = 0; i < 3; i++) bus_wr(16'h3000 + 16'(i));
    tx_fifo_en = 0; step();
    tx_q.delete();
    check("R11 flush", 32'(tx_count), 0);
    bus_wr(16'hBEEF);
    ser_pop();
    check("R11 ignored push", 32'(tx_count), 0);
    check("R11 no errors", 32'(irq_status & 12'h0C0), 0);
    check("R11 port_en rx only", 32'(port_en), 1);
    rx_fifo_en = 0; step();
    check("R11 port_en off", 32'(port_en), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule